// File: doc/BRIEF.md
# Dual-Register Direct Digital Synthesis Core

This core turns a master clock into a periodic waveform code. A 28-bit phase accumulator adds a frequency step on every clock edge. The step comes from one of two frequency slots, picked by a pin. The top twelve accumulator bits are added to one of two 12-bit phase offsets, also picked by a pin, and the sum is registered as the waveform address. From that address a shaping stage produces one of three things: a 10-bit sine code read from a quarter-wave table, a 10-bit triangle code, or a full-scale square code. It also produces a 1-bit clock output taken from the address MSB, either directly or divided by two.

Software loads the slots through a small parallel write port. A 28-bit frequency word arrives as two 14-bit halves. The low half is held in a staging register and only goes live when the high half is written, so the accumulator never runs on a half-updated step. A sleep pin parks the amplitude code at mid-scale while the clock output keeps running. An asynchronous reset clears all state and holds the code at mid-scale.

Top module: `dds_core`

## Requirements
- R1: On every clock edge after reset the accumulator adds the step of the selected frequency slot, modulo 2^28. It starts from zero after reset, and a step of zero leaves it unchanged.
- R2: The address MSB, and so `clk_out` with `clk_half`=0, completes one period for each 2^28 / F clocks at step F. For example, 0x5555555 gives 1000±1 rising edges in 3000 clocks and 0x2492492 gives 1000±1 rising edges in 7000 clocks.
- R3: `freq_pick` chooses slot 0 (0) or slot 1 (1) as the step. The choice is used from the next edge.
- R4: The write select codes are: 0 stages the low half of frequency slot 0, 2 stages the low half of slot 1, 1 and 3 write the high half of slot 0 and slot 1. A high-half write commits {wr_data, staged low half} to the slot. A low-half write alone leaves the active step unchanged, and codes 6 and 7 change nothing.
- R5: Codes 4 and 5 load `wr_data[11:0]` into phase slot 0 and phase slot 1. `phase_pick` selects the slot. The address is (accumulator[27:16] + selected offset) mod 4096.
- R6: With `wave_mode`=0 and address a, the code is 512+floor(512·sin(2π(a+0.5)/4096)) for a<2048 and 511−floor(−512·sin(2π(a+0.5)/4096)) otherwise, within ±1.
- R7: With `wave_mode`=1 the code is a[10:1] for a<2048 and 1023−a[10:1] otherwise.
- R8: With `wave_mode`=2 or 3 the code is 1023 when a[11]=1 and 0 otherwise.
- R9: With `clk_half`=0, `clk_out` equals a[11]. With `clk_half`=1 it follows a divide-by-two flop that starts at 0 after reset and toggles on every rising edge of a[11]. That flop runs in both settings.
- R10: While `sleep`=1 the code is 512 whatever the mode. `clk_out` is not affected by sleep.
- R11: While `rst_n`=0 (asynchronous, active low), all slots, staging registers and the accumulator are cleared, the code is 512 and `clk_out` is 0.
- R12: The address is registered one edge after the accumulator, and the code and `clk_out` one edge after the address. A slot write committed at edge k shows at the outputs at edge k+3. A change to `phase_pick` shows at edge k+2. A change to `wave_mode`, `sleep` or `clk_half` shows at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the parallel port |
| wr_sel | input | 3 | Target register select (codes in R4, R5) |
| wr_data | input | 14 | Write data: a frequency half, or a phase offset in [11:0] |
| freq_pick | input | 1 | Frequency slot select |
| phase_pick | input | 1 | Phase slot select |
| wave_mode | input | 2 | 0 sine, 1 triangle, 2 or 3 square |
| clk_half | input | 1 | Route the divide-by-two flop to `clk_out` |
| sleep | input | 1 | Park the amplitude code at mid-scale |
| amp_code | output | 10 | Unsigned amplitude code |
| clk_out | output | 1 | Clock output from the address MSB |

## Verification
The path has three register stages: accumulator, address, output. A new step therefore reaches `amp_code` two edges after the accumulator takes it. A committed write reaches it three edges after the write, and a mode or sleep change one edge later. The bench keeps its own arithmetic model with the same stage count, advances it on each rising edge, and compares both outputs one nanosecond after that edge. A shift by a single cycle in any stage shows up as a mismatch. The frequency checks count `clk_out` rising edges over long windows, and the reset checks sample straight after the asynchronous assertion.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE = 2'd0,
        WAVE_TRI  = 2'd1,
        WAVE_SQR  = 2'd2,
        WAVE_SQR2 = 2'd3
    } wave_e;

    // write-port select codes; bit 2 splits frequency from phase targets
    localparam logic [2:0] SEL_F0_LO = 3'd0;
    localparam logic [2:0] SEL_F0_HI = 3'd1;
    localparam logic [2:0] SEL_F1_LO = 3'd2;
    localparam logic [2:0] SEL_F1_HI = 3'd3;
    localparam logic [2:0] SEL_P0    = 3'd4;
    localparam logic [2:0] SEL_P1    = 3'd5;

endpackage

// File: rtl/dds_regs.sv
module dds_regs #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [2:0]            wr_sel_i,
    input  logic [ACC_W/2-1:0]    wr_data_i,
    input  logic                  freq_pick_i,
    input  logic                  phase_pick_i,
    output logic [ACC_W-1:0]      step_o,
    output logic [PH_W-1:0]       poff_o
);
    localparam int HALF_W = ACC_W / 2;
    localparam int SLOTS  = 2;

    typedef struct packed {
        logic [SLOTS-1:0][ACC_W-1:0]  freq;
        logic [SLOTS-1:0][HALF_W-1:0] lo;
        logic [SLOTS-1:0][PH_W-1:0]   phase;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (!wr_sel_i[2]) begin
                if (!wr_sel_i[0]) begin
                    st_d.lo[wr_sel_i[1]] = wr_data_i;
                end else begin
                    st_d.freq[wr_sel_i[1]] = {wr_data_i, st_q.lo[wr_sel_i[1]]};
                end
            end else if (!wr_sel_i[1]) begin
                st_d.phase[wr_sel_i[0]] = wr_data_i[PH_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign step_o = st_q.freq[freq_pick_i];
    assign poff_o = st_q.phase[phase_pick_i];

    // R4
    lo_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_sel_i[2] && !wr_sel_i[0]) |=> $stable(st_q.freq));

    // R4
    hi_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == dds_pkg::SEL_F0_HI)
        |=> st_q.freq[0] == {$past(wr_data_i), $past(st_q.lo[0])});

    // R4
    unused_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i[2] && wr_sel_i[1]) |=> $stable(st_q));

endmodule

// File: rtl/dds_phase.sv
module dds_phase #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ACC_W-1:0] step_i,
    input  logic [PH_W-1:0]  poff_i,
    output logic [PH_W-1:0]  addr_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PH_W-1:0]  addr;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.acc  = st_q.acc + step_i;
        st_d.addr = st_q.acc[ACC_W-1 -: PH_W] + poff_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    // R1
    zero_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i == '0) |=> $stable(st_q.acc));

    // R5
    offset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (poff_i == '0) |=> addr_o == $past(st_q.acc[ACC_W-1 -: PH_W]));

endmodule

// File: rtl/dds_shape.sv
module dds_shape
    import dds_pkg::*;
#(
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PH_W-1:0]  addr_i,
    input  wave_e            wave_i,
    input  logic             half_i,
    input  logic             sleep_i,
    output logic [OUT_W-1:0] amp_o,
    output logic             clk_o
);
    localparam int QW     = PH_W - 2;
    localparam int QDEPTH = 1 << QW;
    localparam int MAG_W  = OUT_W - 1;
    localparam int MID    = 1 << MAG_W;
    localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(MID);

    function automatic logic [QDEPTH*MAG_W-1:0] build_quarter();
        logic [QDEPTH*MAG_W-1:0] r;
        real ang;
        int  v;
        r = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            ang = (2.0 * 3.14159265358979 * (real'(i) + 0.5)) / real'(4 * QDEPTH);
            v   = int'($floor(real'(MID) * $sin(ang)));
            if (v > MID - 1) v = MID - 1;
            if (v < 0)       v = 0;
            r[i*MAG_W +: MAG_W] = v[MAG_W-1:0];
        end
        return r;
    endfunction

    localparam logic [QDEPTH*MAG_W-1:0] QROM = build_quarter();

    typedef struct packed {
        logic [OUT_W-1:0] amp;
        logic             clk;
        logic             tog;
        logic             msb_prev;
    } sh_state_t;

    sh_state_t st_d, st_q;

    logic             msb;
    logic [QW-1:0]    q_idx;
    logic [MAG_W-1:0] mag;
    logic [OUT_W-1:0] sine_code;
    logic [OUT_W-1:0] tri_code;

    always_comb begin
        msb       = addr_i[PH_W-1];
        q_idx     = addr_i[PH_W-2] ? ~addr_i[QW-1:0] : addr_i[QW-1:0];
        mag       = QROM[int'(q_idx)*MAG_W +: MAG_W];
        sine_code = msb ? (MID_CODE - OUT_W'(1) - OUT_W'(mag)) : (MID_CODE + OUT_W'(mag));
        tri_code  = msb ? ~addr_i[PH_W-2 -: OUT_W] : addr_i[PH_W-2 -: OUT_W];

        st_d          = st_q;
        st_d.tog      = st_q.tog ^ (msb & ~st_q.msb_prev);
        st_d.msb_prev = msb;
        st_d.clk      = half_i ? st_d.tog : msb;

        if (sleep_i) begin
            st_d.amp = MID_CODE;
        end else begin
            unique case (wave_i)
                WAVE_SINE: st_d.amp = sine_code;
                WAVE_TRI:  st_d.amp = tri_code;
                default:   st_d.amp = {OUT_W{msb}};
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.amp      <= MID_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign amp_o = st_q.amp;
    assign clk_o = st_q.clk;

    // R6
    sine_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_i == WAVE_SINE && !sleep_i) |=> amp_o[OUT_W-1] == ~$past(addr_i[PH_W-1]));

    // R7
    tri_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_i == WAVE_TRI && !sleep_i && addr_i[PH_W-1:1] == '0) |=> amp_o == '0);

    // R10
    sleep_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> amp_o == MID_CODE);

    // R9
    direct_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!half_i && sleep_i) |=> clk_o == $past(addr_i[PH_W-1]));

endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [ACC_W/2-1:0] wr_data,
    input  logic               freq_pick,
    input  logic               phase_pick,
    input  logic [1:0]         wave_mode,
    input  logic               clk_half,
    input  logic               sleep,
    output logic [OUT_W-1:0]   amp_code,
    output logic               clk_out
);
    logic [ACC_W-1:0] step;
    logic [PH_W-1:0]  poff;
    logic [PH_W-1:0]  addr;
    wave_e            wave;

    assign wave = wave_e'(wave_mode);

    dds_regs #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .freq_pick_i  (freq_pick),
        .phase_pick_i (phase_pick),
        .step_o       (step),
        .poff_o       (poff)
    );

    dds_phase #(.ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .step_i (step),
        .poff_i (poff),
        .addr_o (addr)
    );

    dds_shape #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shape (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .wave_i  (wave),
        .half_i  (clk_half),
        .sleep_i (sleep),
        .amp_o   (amp_code),
        .clk_o   (clk_out)
    );

endmodule

// File: tb/tb_dds_core.sv
`timescale 1ns/1ps
module tb_dds_core;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [13:0] wr_data = '0;
    logic        freq_pick = 1'b0, phase_pick = 1'b0;
    logic [1:0]  wave_mode = 2'd0;
    logic        clk_half = 1'b0, sleep = 1'b0;
    logic [9:0]  amp_code;
    logic        clk_out;

    always #2.5 clk = ~clk;

    dds_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .freq_pick(freq_pick), .phase_pick(phase_pick), .wave_mode(wave_mode),
        .clk_half(clk_half), .sleep(sleep), .amp_code(amp_code), .clk_out(clk_out)
    );

    int    checks = 0, bad = 0;
    string tag = "R11";
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sine_val(int p);
        real s;
        s = $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0);
        if (p < 2048) return 512 + int'($floor(512.0 * s));
        return 511 - int'($floor(-512.0 * s));
    endfunction

    function automatic int code_for(int p, logic [1:0] w);
        int h;
        h = (p >> 1) & 1023;
        case (w)
            2'd0:    return sine_val(p);
            2'd1:    return (p < 2048) ? h : 1023 - h;
            default: return (p >= 2048) ? 1023 : 0;
        endcase
    endfunction

    // arithmetic reference, three stages as in R12
    logic [27:0] m_freq [2];
    logic [13:0] m_lo   [2];
    logic [11:0] m_ph   [2];
    logic [27:0] m_acc;
    logic [11:0] m_addr;
    int          m_amp;
    bit          m_sine, m_clk, m_tog, m_prev, m_rise;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_freq[0] = '0; m_freq[1] = '0; m_lo[0] = '0; m_lo[1] = '0;
            m_ph[0] = '0; m_ph[1] = '0; m_acc = '0; m_addr = '0;
            m_amp = 512; m_sine = 1'b0; m_clk = 1'b0; m_tog = 1'b0; m_prev = 1'b0;
        end else begin
            m_rise = m_addr[11] & ~m_prev;
            m_tog  = m_tog ^ m_rise;
            m_prev = m_addr[11];
            m_clk  = clk_half ? m_tog : m_addr[11];
            m_sine = (wave_mode == 2'd0) && !sleep;
            m_amp  = sleep ? 512 : code_for(int'(m_addr), wave_mode);
            m_addr = m_acc[27:16] + m_ph[phase_pick];
            m_acc  = m_acc + m_freq[freq_pick];
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_lo[0] = wr_data;
                    3'd2: m_lo[1] = wr_data;
                    3'd1: m_freq[0] = {wr_data, m_lo[0]};
                    3'd3: m_freq[1] = {wr_data, m_lo[1]};
                    3'd4: m_ph[0] = wr_data[11:0];
                    3'd5: m_ph[1] = wr_data[11:0];
                    default: ;
                endcase
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (chk_on) begin : cmp
            int d;
            d = int'(amp_code) - m_amp;
            check(m_sine ? (d >= -1 && d <= 1) : (d == 0), tag, int'(amp_code), m_amp);
            check(clk_out == m_clk, tag, int'(clk_out), int'(m_clk));
        end
    end

    task automatic wr(input logic [2:0] s, input logic [13:0] v);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_freq(input int slot, input logic [27:0] w);
        wr(3'(slot * 2), w[13:0]);
        wr(3'(slot * 2 + 1), w[27:14]);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_rises(input int n, output int c);
        logic prev;
        c = 0;
        @(posedge clk); #1; prev = clk_out;
        repeat (n) begin
            @(posedge clk); #1;
            if (clk_out && !prev) c++;
            prev = clk_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int c;
        // R11: reset state
        repeat (3) @(negedge clk);
        check(amp_code == 10'd512, "R11", int'(amp_code), 512);
        check(clk_out == 1'b0, "R11", int'(clk_out), 0);
        @(negedge clk); rst_n = 1'b1; chk_on = 1'b1;

        // R6: one address step per clock, full sine sweep
        tag = "R6";
        set_freq(0, 28'h0010000);
        run(4200);

        // R7: triangle sweep, and a mode change landing at the next edge (R12)
        tag = "R7";
        @(negedge clk); wave_mode = 2'd1;
        run(4200);

        // R8: square codes 2 and 3
        tag = "R8";
        @(negedge clk); wave_mode = 2'd2; run(300);
        @(negedge clk); wave_mode = 2'd3; run(300);

        // R5: phase offsets and selection
        tag = "R5";
        @(negedge clk); wave_mode = 2'd0;
        wr(3'd5, 14'h0355);
        @(negedge clk); phase_pick = 1'b1; run(300);
        wr(3'd4, 14'h20AB);
        @(negedge clk); phase_pick = 1'b0; run(300);

        // R3: second frequency slot
        tag = "R3";
        @(negedge clk); wave_mode = 2'd1;
        set_freq(1, 28'h0123457);
        @(negedge clk); freq_pick = 1'b1; run(500);
        @(negedge clk); freq_pick = 1'b0; run(100);

        // R4: low half alone keeps the old step; unused codes do nothing
        tag = "R4";
        wr(3'd0, 14'h3FFF); run(200);
        wr(3'd6, 14'h1234); wr(3'd7, 14'h0FFF); run(100);
        wr(3'd1, 14'h0008); run(300);

        // R12: committed write to the live slot, exact-cycle tracking
        tag = "R12";
        set_freq(0, 28'h0021000); run(200);

        // R1: step of all ones walks backwards through wrap-around
        tag = "R1";
        set_freq(0, 28'hFFFFFFF); run(300);
        set_freq(0, 28'h0000000); run(100);

        // R2: output rate
        tag = "R2";
        @(negedge clk); wave_mode = 2'd2;
        set_freq(0, 28'h5555555);
        count_rises(3000, c);
        check(c >= 999 && c <= 1001, "R2", c, 1000);
        set_freq(0, 28'h2492492);
        count_rises(7000, c);
        check(c >= 999 && c <= 1001, "R2", c, 1000);

        // R9: halved clock output
        tag = "R9";
        set_freq(0, 28'h5555555);
        @(negedge clk); clk_half = 1'b1;
        count_rises(3000, c);
        check(c >= 499 && c <= 501, "R9", c, 500);
        set_freq(0, 28'h0040000);
        run(600);
        @(negedge clk); clk_half = 1'b0; run(200);

        // R10: sleep parks the code, clock output keeps running
        tag = "R10";
        set_freq(0, 28'h5555555);
        @(negedge clk); sleep = 1'b1; wave_mode = 2'd0;
        count_rises(300, c);
        check(c >= 99 && c <= 101, "R10", c, 100);
        check(amp_code == 10'd512, "R10", int'(amp_code), 512);
        @(negedge clk); sleep = 1'b0; run(200);

        // R11: asynchronous reset mid-run
        @(negedge clk); chk_on = 1'b0; rst_n = 1'b0;
        #1;
        check(amp_code == 10'd512, "R11", int'(amp_code), 512);
        check(clk_out == 1'b0, "R11", int'(clk_out), 0);
        run(4);
        check(amp_code == 10'd512, "R11", int'(amp_code), 512);
        @(negedge clk); rst_n = 1'b1; tag = "R11"; chk_on = 1'b1;
        run(50);
        check(amp_code == 10'd512, "R11", int'(amp_code), 512);

        chk_on = 1'b0;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule